// File: doc/BRIEF.md
# Fixed-Slot Machine Cycle Scheduler

This block cuts the processor clock into machine cycles of fixed length and groups twenty of them into a process cycle. The twenty slots are laid out either as four lines of five machine cycles or as five lines of four. The last machine cycle of every line is reserved as a timing slot, and every other slot is flagged as free for user work. Firmware-style video timing is derived from this schedule, not from a pixel counter: each timing slot is one horizontal sync event, and a field is a fixed number of process cycles.

A 2-bit scheme select picks both the line arrangement (bit 1) and the number of process cycles per field (bit 1 and bit 0 together). The select is taken up only at a field boundary, so a field never mixes two arrangements. The block gives out a machine-cycle strobe, the slot flags, a line counter within the field, a field counter, and hsync and vsync.

Top module: `slot_sched`

## Requirements
- R1: A machine cycle lasts exactly CLKS_PER_MC clocks. mc_stb_o is high for the first clock of every machine cycle and low for the others. The first machine cycle starts at the clock in which reset is released.
- R2: A process cycle is 20 machine cycles. With scheme bit 1 = 0 it is 4 lines of 5 machine cycles. With scheme bit 1 = 1 it is 5 lines of 4 machine cycles.
- R3: The last machine cycle of each line is a timing slot: timing_slot_o is high and user_slot_o is low for all of its clocks. In every other machine cycle the two flags are the other way round. This gives 16 user slots per process cycle in the 4-line arrangement and 15 in the 5-line arrangement.
- R4: hsync_o is high exactly while timing_slot_o is high. Successive hsync rising edges are lines × CLKS_PER_MC clocks apart, where lines is the number of machine cycles per line (215 clocks for the 4-line arrangement at the default setting).
- R5: A field lasts PC_FIELD_n process cycles for scheme n. The defaults are 128 (n=0) and 160 (n=1) in the 4-line arrangement, and 96 (n=2) and 120 (n=3) in the 5-line arrangement.
- R6: line_o is 0 in the first line of a field and steps by one at each line end, so it reaches lines-per-field − 1. field_o steps by one at each field end and wraps modulo 2^FIELD_W.
- R7: scheme_i is sampled only on the last clock of a field. The field that starts at reset uses scheme 0. A change of scheme_i within a field has no effect on that field.
- R8: vsync_o is high during the first VSYNC_LINES lines of each field and low otherwise. It therefore covers exactly VSYNC_LINES timing slots per field.
- R9: While reset is held: line_o = 0, field_o = 0, mc_stb_o = 1, timing_slot_o = 0, user_slot_o = 1, hsync_o = 0, vsync_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scheme_i | input | 2 | Timing scheme select; bit 1 picks 5x4 arrangement |
| mc_stb_o | output | 1 | High on first clock of each machine cycle |
| timing_slot_o | output | 1 | Current machine cycle is the line's timing slot |
| user_slot_o | output | 1 | Current machine cycle is free for user work |
| line_o | output | LINE_W | Line index within the field |
| field_o | output | FIELD_W | Field counter |
| hsync_o | output | 1 | Horizontal sync, one timing slot per line |
| vsync_o | output | 1 | Vertical sync over the first lines of a field |

## Verification
The bench builds the block with CLKS_PER_MC = 3, process cycles per field of 4, 6, 3 and 5 for the four schemes, VSYNC_LINES = 2 and FIELD_W = 2. With these values a whole field lasts a few hundred clocks. Every scheme, a scheme change made in the middle of a field, and the wrap of the field counter can therefore each be counted slot by slot against the arithmetic. The same slot, line and field arithmetic then applies to the default 43-clock cycles with 128 or 160 process cycles per field.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

  localparam int NUM_SCHEMES = 4;
  localparam int MC_PER_PC   = 20;

  typedef enum logic {
    ARR_4X5 = 1'b0,
    ARR_5X4 = 1'b1
  } arrange_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int lines_of(input arrange_e a);
    return (a == ARR_5X4) ? 5 : 4;
  endfunction

  function automatic int slots_of(input arrange_e a);
    return (a == ARR_5X4) ? 4 : 5;
  endfunction

endpackage

// File: rtl/mc_divider.sv
module mc_divider #(
  parameter int CLKS_PER_MC = 43
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mc_stb_o,
  output logic mc_end_o
);
  localparam int CW = (CLKS_PER_MC > 2) ? $clog2(CLKS_PER_MC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CW'(1);
  end

  assign mc_stb_o = (cnt_q == '0);
  assign mc_end_o = (cnt_q == LAST);

  // R1
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_stb_o |=> !mc_stb_o);
  // R1
  mc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_end_o |=> mc_stb_o);

endmodule

// File: rtl/line_sequencer.sv
module line_sequencer
  import slot_sched_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mc_end_i,
  input  arrange_e arr_i,
  output logic     timing_slot_o,
  output logic     line_end_o,
  output logic     pc_end_o
);
  logic [2:0] slot_q, line_q;
  logic [2:0] slot_last, line_last;

  assign slot_last = 3'(slots_of(arr_i) - 1);
  assign line_last = 3'(lines_of(arr_i) - 1);

  assign timing_slot_o = (slot_q == slot_last);
  assign line_end_o    = mc_end_i && timing_slot_o;
  assign pc_end_o      = line_end_o && (line_q == line_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      line_q <= '0;
    end else if (mc_end_i) begin
      if (timing_slot_o) begin
        slot_q <= '0;
        line_q <= (line_q == line_last) ? 3'd0 : line_q + 3'd1;
      end else begin
        slot_q <= slot_q + 3'd1;
      end
    end
  end

  // R3
  timing_one_mc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timing_slot_o && mc_end_i) |=> !timing_slot_o);
  // R2
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mc_end_i |=> ($stable(slot_q) && $stable(line_q)));

endmodule

// File: rtl/field_tracker.sv
module field_tracker
  import slot_sched_pkg::*;
#(
  parameter int PC_FIELD_0  = 128,
  parameter int PC_FIELD_1  = 160,
  parameter int PC_FIELD_2  = 96,
  parameter int PC_FIELD_3  = 120,
  parameter int VSYNC_LINES = 4,
  parameter int PC_W        = 8,
  parameter int LINE_W      = 10,
  parameter int FIELD_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_end_i,
  input  logic               pc_end_i,
  input  logic [1:0]         scheme_i,
  output arrange_e           arr_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [FIELD_W-1:0] field_o,
  output logic               vsync_o
);
  localparam int PC_TAB [NUM_SCHEMES] = '{PC_FIELD_0, PC_FIELD_1, PC_FIELD_2, PC_FIELD_3};

  logic [1:0]         scheme_q;
  logic [PC_W-1:0]    pc_q;
  logic [LINE_W-1:0]  line_q;
  logic [FIELD_W-1:0] field_q;
  logic [PC_W-1:0]    pc_last_tab [NUM_SCHEMES];
  logic               field_end;

  for (genvar g = 0; g < NUM_SCHEMES; g++) begin : g_pc_last
    assign pc_last_tab[g] = PC_W'(PC_TAB[g] - 1);
  end

  assign field_end = pc_end_i && (pc_q == pc_last_tab[scheme_q]);
  assign arr_o     = arrange_e'(scheme_q[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scheme_q <= 2'd0;
      pc_q     <= '0;
      line_q   <= '0;
      field_q  <= '0;
    end else if (field_end) begin
      scheme_q <= scheme_i;
      pc_q     <= '0;
      line_q   <= '0;
      field_q  <= field_q + FIELD_W'(1);
    end else begin
      if (pc_end_i)   pc_q   <= pc_q + PC_W'(1);
      if (line_end_i) line_q <= line_q + LINE_W'(1);
    end
  end

  assign line_o  = line_q;
  assign field_o = field_q;
  assign vsync_o = (line_q < LINE_W'(VSYNC_LINES));

  // R7
  scheme_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_end |=> $stable(scheme_q));
  // R8
  vsync_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |-> (line_q == '0));
  // R6
  field_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_end |=> $stable(field_q));

endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int CLKS_PER_MC = 43,
  parameter int PC_FIELD_0  = 128,
  parameter int PC_FIELD_1  = 160,
  parameter int PC_FIELD_2  = 96,
  parameter int PC_FIELD_3  = 120,
  parameter int VSYNC_LINES = 4,
  parameter int FIELD_W     = 8,
  localparam int MAX_PC     = max_int(max_int(PC_FIELD_0, PC_FIELD_1),
                                      max_int(PC_FIELD_2, PC_FIELD_3)),
  localparam int LINE_W     = $clog2(MAX_PC * 5 + 1),
  localparam int PC_W       = (MAX_PC > 2) ? $clog2(MAX_PC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         scheme_i,
  output logic               mc_stb_o,
  output logic               timing_slot_o,
  output logic               user_slot_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [FIELD_W-1:0] field_o,
  output logic               hsync_o,
  output logic               vsync_o
);
  logic     mc_end;
  logic     line_end, pc_end;
  arrange_e arr;

  mc_divider #(.CLKS_PER_MC(CLKS_PER_MC)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mc_stb_o (mc_stb_o),
    .mc_end_o (mc_end)
  );

  line_sequencer u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mc_end_i      (mc_end),
    .arr_i         (arr),
    .timing_slot_o (timing_slot_o),
    .line_end_o    (line_end),
    .pc_end_o      (pc_end)
  );

  field_tracker #(
    .PC_FIELD_0  (PC_FIELD_0),
    .PC_FIELD_1  (PC_FIELD_1),
    .PC_FIELD_2  (PC_FIELD_2),
    .PC_FIELD_3  (PC_FIELD_3),
    .VSYNC_LINES (VSYNC_LINES),
    .PC_W        (PC_W),
    .LINE_W      (LINE_W),
    .FIELD_W     (FIELD_W)
  ) u_fld (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_end_i (line_end),
    .pc_end_i   (pc_end),
    .scheme_i   (scheme_i),
    .arr_o      (arr),
    .line_o     (line_o),
    .field_o    (field_o),
    .vsync_o    (vsync_o)
  );

  assign user_slot_o = !timing_slot_o;
  assign hsync_o     = timing_slot_o;

  // R4
  hsync_in_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_o) |-> mc_stb_o);

endmodule

// File: tb/tb_slot_sched.sv
module tb_slot_sched;
  localparam int CLKS  = 3;
  localparam int VSL   = 2;
  localparam int FW    = 2;
  localparam int LW    = 5;
  localparam int PCT [4] = '{4, 6, 3, 5};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    scheme = 2'd2;
  logic          mc_stb, tslot, uslot, hs, vs;
  logic [LW-1:0] line;
  logic [FW-1:0] field;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  slot_sched #(
    .CLKS_PER_MC(CLKS), .PC_FIELD_0(4), .PC_FIELD_1(6), .PC_FIELD_2(3),
    .PC_FIELD_3(5), .VSYNC_LINES(VSL), .FIELD_W(FW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .scheme_i(scheme), .mc_stb_o(mc_stb),
    .timing_slot_o(tslot), .user_slot_o(uslot), .line_o(line),
    .field_o(field), .hsync_o(hs), .vsync_o(vs)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_check();
    @(negedge clk);
    chk(mc_stb == 1'b1, "R9 mc_stb in reset", int'(mc_stb), 1);
    chk(tslot == 1'b0 && uslot == 1'b1, "R9 slot flags in reset", int'(tslot), 0);
    chk(hs == 1'b0 && vs == 1'b1, "R9 syncs in reset", int'({hs, vs}), 1);
    chk(line == '0 && field == '0, "R9 counters in reset", int'(line), 0);
    rst_n = 1'b1;
  endtask

  // Runs from the first clock of a field to the first clock of the next.
  task automatic run_field(input int sch, input logic [1:0] nxt, input bit glitch);
    int mpl   = sch[1] ? 4 : 5;
    int lpp   = sch[1] ? 5 : 4;
    int pc    = PCT[sch];
    int exp_clk = 20 * pc * CLKS;
    int clocks = 0, mcs = 0, tcnt = 0, ucnt = 0, hr = 0, vsl = 0;
    int maxline = 0, since = 0, badper = 0, hmis = 0;
    logic prev_h = 1'b0;
    logic [FW-1:0] f0 = field;
    chk(line == '0 && vs == 1'b1, $sformatf("R8 field start sch%0d", sch), int'(line), 0);
    scheme = nxt;
    do begin
      if (glitch && clocks == exp_clk / 2) scheme = ~nxt;
      if (glitch && clocks == (exp_clk * 3) / 4) scheme = nxt;
      clocks++;
      since++;
      if (mc_stb) begin
        mcs++;
        if (tslot) tcnt++;
        if (uslot) ucnt++;
        if (tslot && vs) vsl++;
      end
      if (hs != tslot) hmis++;
      if (hs && !prev_h) begin
        if (hr > 0 && since != mpl * CLKS) badper++;
        hr++;
        since = 0;
      end
      prev_h = hs;
      if (int'(line) > maxline) maxline = int'(line);
      @(negedge clk);
    end while (field == f0 && clocks < 2 * exp_clk + 50);
    chk(clocks == exp_clk, $sformatf("R5 field clocks sch%0d", sch), clocks, exp_clk);
    chk(mcs == 20 * pc, $sformatf("R1 mc strobes sch%0d", sch), mcs, 20 * pc);
    chk(tcnt == lpp * pc, $sformatf("R2 timing slots sch%0d", sch), tcnt, lpp * pc);
    chk(ucnt == (20 - lpp) * pc, $sformatf("R3 user slots sch%0d", sch), ucnt, (20 - lpp) * pc);
    chk(hr == lpp * pc, $sformatf("R4 hsync pulses sch%0d", sch), hr, lpp * pc);
    chk(badper == 0 && hmis == 0, $sformatf("R4 hsync period sch%0d", sch), badper + hmis, 0);
    chk(vsl == VSL, $sformatf("R8 vsync lines sch%0d", sch), vsl, VSL);
    chk(maxline == lpp * pc - 1, $sformatf("R6 last line sch%0d", sch), maxline, lpp * pc - 1);
    chk(field == FW'(f0 + 1), $sformatf("R6 field step sch%0d", sch), int'(field), int'(FW'(f0 + 1)));
  endtask

  initial begin
    reset_check();
    run_field(0, 2'd2, 1'b0);   // R7: reset field uses scheme 0 despite select 2
    run_field(2, 2'd1, 1'b1);   // R7: mid-field change ignored
    run_field(1, 2'd3, 1'b0);
    run_field(3, 2'd0, 1'b0);
    chk(field == '0, "R6 field wrap", int'(field), 0);
    run_field(0, 2'd0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule